// File: doc/BRIEF.md
# Clock Calibration Counter

This block measures the rate of one clock against another inside a single system clock domain. Each clock source reaches the block as a synchronised one-cycle strobe, one per rising edge of that source. Software picks a measured source, a reference source and a window length in measured-clock cycles, then sets the start bit. The block then counts reference strobes while the window runs. When the window closes it stores the count as the result and drops the start bit. It can also raise an interrupt.

The control path is a three-state machine:

- `ST_IDLE`: waits for a start write. Configuration writes are accepted only in this state.
- `ST_COUNT`: counts reference strobes until the programmed number of measured strobes has arrived.
- `ST_FINISH`: stores the result, clears the start bit and may set the interrupt.

The transitions are:

- `IDLE->COUNT`: a start write with a non-zero window.
- `IDLE->FINISH`: a start write with a zero window.
- `COUNT->FINISH`: the last measured strobe of the window.
- `FINISH->IDLE`: always, after one cycle.

Software can poll the start bit, or wait for the interrupt, whose status bit is active low.

Top module: `clk_cal_counter`

## Requirements
- R1: After reset the following all read 0: start bit, result, selects, window length and interrupt enable. `irq_status_n_o` reads 1 and `irq_o` reads 0.
- R2: The measured-source select maps to bits of `meas_tick_i`: 0 = low-power RC, 1 = 32 MHz RC, 2 = 32 kHz crystal, 3 = RCX-type RC, 4 = RC oscillator.
- R3: The reference select maps to bits of `ref_tick_i`: 0 = divided system clock, 1 = low-power RC, 2 = 32 MHz RC, 3 = 32 kHz crystal, 4 = RC oscillator, 5 = external input.
- R4: The result equals the number of selected reference strobes over a window. The window runs from the cycle after the start edge up to and including the cycle that carries the N-th selected measured strobe, where N is the 16-bit window length.
- R5: `start_o` reads 1 from the edge that accepts a start until completion. It returns to 0 on the same edge that loads the new result, one cycle after the cycle of the last measured strobe.
- R6: While `start_o` is 1, configuration writes and further start writes have no effect.
- R7: A window length of 0 gives a result of 0. `start_o` is 1 for exactly one cycle.
- R8: The result counter saturates at all ones and never wraps.
- R9: Completion sets the pending flag only if the interrupt enable is 1 in the completion cycle. While the flag is pending, `irq_status_n_o` is 0 and `irq_o` is 1.
- R10: `irq_clr_i` clears the pending flag. When completion and clear fall in the same cycle, the flag stays set.
- R11: A configuration write and a start write in the same idle cycle start a window with the newly written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| meas_tick_i | input | 5 | Synchronised edge strobes of the measurable sources |
| ref_tick_i | input | 6 | Synchronised edge strobes of the reference sources |
| cfg_wr_i | input | 1 | Write strobe for selects and window length |
| cfg_meas_sel_i | input | 3 | Measured-source select to write |
| cfg_ref_sel_i | input | 3 | Reference select to write |
| cfg_cycles_i | input | CNT_W | Window length to write |
| start_wr_i | input | 1 | Write one to the start bit |
| irq_en_wr_i | input | 1 | Write strobe for interrupt enable |
| irq_en_i | input | 1 | Interrupt enable value to write |
| irq_clr_i | input | 1 | Write-one clear of the pending flag |
| meas_sel_o | output | 3 | Stored measured-source select |
| ref_sel_o | output | 3 | Stored reference select |
| cycles_o | output | CNT_W | Stored window length |
| irq_en_o | output | 1 | Stored interrupt enable |
| start_o | output | 1 | Start bit readback (1 while busy) |
| result_o | output | RES_W | Last stored calibration count |
| irq_status_n_o | output | 1 | Interrupt status, 0 when pending |
| irq_o | output | 1 | Interrupt request, 1 when pending |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is completion and the interrupt clear. The bench watches its own model for the finish cycle and drives `irq_clr_i` exactly there, with the flag already pending. It then expects the flag to remain set. The model applies the clear first and the set after it.

The second pair is a configuration write and a start write. The bench issues both together, after a zero-length window was stored. It judges the outcome by the start bit: it must still be high two edges later, which a stale zero window would not allow.

// File: rtl/clk_cal_pkg.sv
package clk_cal_pkg;

    localparam int MEAS_SRCS = 5;
    localparam int REF_SRCS  = 6;
    localparam int MSEL_W    = $clog2(MEAS_SRCS);
    localparam int RSEL_W    = $clog2(REF_SRCS);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_FINISH = 2'd2
    } cal_state_e;

endpackage

// File: rtl/clk_cal_src_mux.sv
module clk_cal_src_mux #(
    parameter int N     = 5,
    parameter int SEL_W = 3
) (
    input  logic [N-1:0]     tick_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    logic [N-1:0] hit;

    // One comparator per source; codes with no source select nothing.
    for (genvar g = 0; g < N; g++) begin : g_hit
        assign hit[g] = tick_i[g] && (sel_i == SEL_W'(g));
    end

    assign tick_o = |hit;

endmodule

// File: rtl/clk_cal_window.sv
module clk_cal_window #(
    parameter int CNT_W = 16,
    parameter int RES_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] cycles_i,
    input  logic             run_i,
    input  logic             meas_tick_i,
    input  logic             ref_tick_i,
    output logic             last_o,
    output logic [RES_W-1:0] acc_o
);

    localparam logic [RES_W-1:0] ACC_MAX = '1;
    localparam logic [CNT_W-1:0] REM_ONE = CNT_W'(1);

    logic [CNT_W-1:0] rem_q;
    logic [RES_W-1:0] acc_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rem_q <= '0;
            acc_q <= '0;
        end else if (load_i) begin
            rem_q <= cycles_i;
            acc_q <= '0;
        end else if (run_i) begin
            if (meas_tick_i) begin
                rem_q <= rem_q - REM_ONE;
            end
            if (ref_tick_i && (acc_q != ACC_MAX)) begin
                acc_q <= acc_q + RES_W'(1);
            end
        end
    end

    assign last_o = run_i && meas_tick_i && (rem_q == REM_ONE);
    assign acc_o  = acc_q;

    AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !load_i && acc_q == ACC_MAX) |=> (acc_q == ACC_MAX)); // R8

    AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !load_i) |=> (acc_q >= $past(acc_q))); // R8

endmodule

// File: rtl/clk_cal_fsm.sv
module clk_cal_fsm
    import clk_cal_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic zero_i,
    input  logic last_i,
    output logic busy_o,
    output logic load_o,
    output logic run_o,
    output logic store_o
);

    cal_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = zero_i ? ST_FINISH : ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (last_i) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy_o  = 1'b0;
        load_o  = 1'b0;
        run_o   = 1'b0;
        store_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   load_o = start_i;
            ST_COUNT:  begin busy_o = 1'b1; run_o = 1'b1; end
            ST_FINISH: begin busy_o = 1'b1; store_o = 1'b1; end
            default:   ;
        endcase
    end

    AST_ZERO_SKIPS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_IDLE && start_i && zero_i) |=> (state_q == ST_FINISH)); // R7

    AST_FINISH_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_FINISH) |=> (state_q == ST_IDLE)); // R5

endmodule

// File: rtl/clk_cal_counter.sv
module clk_cal_counter
    import clk_cal_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int RES_W = 32
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [MEAS_SRCS-1:0] meas_tick_i,
    input  logic [REF_SRCS-1:0]  ref_tick_i,
    input  logic                 cfg_wr_i,
    input  logic [MSEL_W-1:0]    cfg_meas_sel_i,
    input  logic [RSEL_W-1:0]    cfg_ref_sel_i,
    input  logic [CNT_W-1:0]     cfg_cycles_i,
    input  logic                 start_wr_i,
    input  logic                 irq_en_wr_i,
    input  logic                 irq_en_i,
    input  logic                 irq_clr_i,
    output logic [MSEL_W-1:0]    meas_sel_o,
    output logic [RSEL_W-1:0]    ref_sel_o,
    output logic [CNT_W-1:0]     cycles_o,
    output logic                 irq_en_o,
    output logic                 start_o,
    output logic [RES_W-1:0]     result_o,
    output logic                 irq_status_n_o,
    output logic                 irq_o
);

    logic [MSEL_W-1:0] msel_q, msel_d;
    logic [RSEL_W-1:0] rsel_q, rsel_d;
    logic [CNT_W-1:0]  cyc_q, cyc_d;
    logic [RES_W-1:0]  result_q;
    logic [RES_W-1:0]  acc;
    logic              irq_en_q;
    logic              pend_q;
    logic              busy, load, run, store, last;
    logic              cfg_take;
    logic              meas_tick, ref_tick;

    // Configuration is only taken while idle; a same-cycle start sees it.
    assign cfg_take = cfg_wr_i && !busy;
    assign msel_d   = cfg_take ? cfg_meas_sel_i : msel_q;
    assign rsel_d   = cfg_take ? cfg_ref_sel_i  : rsel_q;
    assign cyc_d    = cfg_take ? cfg_cycles_i   : cyc_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            msel_q <= '0;
            rsel_q <= '0;
            cyc_q  <= '0;
        end else begin
            msel_q <= msel_d;
            rsel_q <= rsel_d;
            cyc_q  <= cyc_d;
        end
    end

    clk_cal_src_mux #(.N(MEAS_SRCS), .SEL_W(MSEL_W)) i_meas_mux (
        .tick_i (meas_tick_i),
        .sel_i  (msel_q),
        .tick_o (meas_tick)
    );

    clk_cal_src_mux #(.N(REF_SRCS), .SEL_W(RSEL_W)) i_ref_mux (
        .tick_i (ref_tick_i),
        .sel_i  (rsel_q),
        .tick_o (ref_tick)
    );

    clk_cal_fsm i_fsm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_wr_i),
        .zero_i  (cyc_d == '0),
        .last_i  (last),
        .busy_o  (busy),
        .load_o  (load),
        .run_o   (run),
        .store_o (store)
    );

    clk_cal_window #(.CNT_W(CNT_W), .RES_W(RES_W)) i_window (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (load),
        .cycles_i    (cyc_d),
        .run_i       (run),
        .meas_tick_i (meas_tick),
        .ref_tick_i  (ref_tick),
        .last_o      (last),
        .acc_o       (acc)
    );

    // Result and interrupt
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            result_q <= '0;
            irq_en_q <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            if (store) begin
                result_q <= acc;
            end
            if (irq_en_wr_i) begin
                irq_en_q <= irq_en_i;
            end
            if (store && irq_en_q) begin
                pend_q <= 1'b1;
            end else if (irq_clr_i) begin
                pend_q <= 1'b0;
            end
        end
    end

    always_comb begin
        meas_sel_o     = msel_q;
        ref_sel_o      = rsel_q;
        cycles_o       = cyc_q;
        irq_en_o       = irq_en_q;
        start_o        = busy;
        result_o       = result_q;
        irq_status_n_o = !pend_q;
        irq_o          = pend_q;
    end

    AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy |=> $stable({msel_q, rsel_q, cyc_q})); // R6

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pend_q) |-> $past(irq_en_q)); // R9

    AST_SET_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (store && irq_en_q) |=> pend_q); // R10

    AST_START_DROPS_AT_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        store |=> !start_o); // R5

endmodule

// File: tb/test_clk_cal_counter.sv
module test_clk_cal_counter;

    localparam int CLK_PERIOD = 10;
    localparam int RES_W      = 10;
    localparam int CNT_W      = 16;
    localparam int RES_MAX    = (1 << RES_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [4:0]       meas_tick = '0;
    logic [5:0]       ref_tick = '0;
    logic             cfg_wr = 1'b0;
    logic [2:0]       cfg_msel = '0;
    logic [2:0]       cfg_rsel = '0;
    logic [CNT_W-1:0] cfg_cyc = '0;
    logic             start_wr = 1'b0;
    logic             en_wr = 1'b0;
    logic             en_val = 1'b0;
    logic             irq_clr = 1'b0;
    logic [2:0]       msel_o, rsel_o;
    logic [CNT_W-1:0] cyc_o;
    logic             en_o, start_o, stat_n_o, irq_o;
    logic [RES_W-1:0] result_o;

    int checks = 0;
    int failures = 0;
    int tcnt = 0;
    int wd = 0;
    bit cmp_on = 0;

    // reference model state
    int m_state, m_rem, m_acc, m_res, m_msel, m_rsel, m_cyc;
    bit m_pend, m_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_cal_counter #(.CNT_W(CNT_W), .RES_W(RES_W)) i_clk_cal_counter (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .meas_tick_i    (meas_tick),
        .ref_tick_i     (ref_tick),
        .cfg_wr_i       (cfg_wr),
        .cfg_meas_sel_i (cfg_msel),
        .cfg_ref_sel_i  (cfg_rsel),
        .cfg_cycles_i   (cfg_cyc),
        .start_wr_i     (start_wr),
        .irq_en_wr_i    (en_wr),
        .irq_en_i       (en_val),
        .irq_clr_i      (irq_clr),
        .meas_sel_o     (msel_o),
        .ref_sel_o      (rsel_o),
        .cycles_o       (cyc_o),
        .irq_en_o       (en_o),
        .start_o        (start_o),
        .result_o       (result_o),
        .irq_status_n_o (stat_n_o),
        .irq_o          (irq_o)
    );

    function automatic int meas_period(int k);
        case (k)
            0: return 7;
            1: return 3;
            2: return 11;
            3: return 5;
            default: return 4;
        endcase
    endfunction

    function automatic int ref_period(int k);
        case (k)
            0: return 2;
            1: return 3;
            2: return 1;
            3: return 5;
            4: return 6;
            default: return 4;
        endcase
    endfunction

    // Source strobes, changed away from the active edge
    always @(negedge clk) begin
        tcnt++;
        for (int k = 0; k < 5; k++) meas_tick[k] <= ((tcnt % meas_period(k)) == 0);
        for (int k = 0; k < 6; k++) ref_tick[k]  <= (((tcnt + k) % ref_period(k)) == 0);
    end

    // Cycle-by-cycle behavioural model
    always @(posedge clk) begin
        int st;
        bit mt, rt;
        if (!rst_n) begin
            m_state = 0; m_rem = 0; m_acc = 0; m_res = 0;
            m_msel = 0; m_rsel = 0; m_cyc = 0; m_pend = 0; m_en = 0;
        end else begin
            st = m_state;
            mt = (m_msel < 5) ? meas_tick[m_msel] : 1'b0;
            rt = (m_rsel < 6) ? ref_tick[m_rsel]  : 1'b0;
            if (irq_clr) m_pend = 0;
            if (st == 2 && m_en) m_pend = 1;
            if (en_wr) m_en = en_val;
            if (st == 0) begin
                if (cfg_wr) begin
                    m_msel = int'(cfg_msel); m_rsel = int'(cfg_rsel); m_cyc = int'(cfg_cyc);
                end
                if (start_wr) begin
                    m_rem = m_cyc; m_acc = 0;
                    m_state = (m_cyc == 0) ? 2 : 1;
                end
            end else if (st == 1) begin
                if (rt && m_acc < RES_MAX) m_acc++;
                if (mt) begin
                    m_rem--;
                    if (m_rem == 0) m_state = 2;
                end
            end else begin
                m_res = m_acc;
                m_state = 0;
            end
        end
    end

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the model on every cycle
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(start_o == (m_state != 0), "R5 start bit", start_o, m_state != 0);
            chk(int'(result_o) == m_res, "R4 result", result_o, m_res);
            chk(stat_n_o == !m_pend && irq_o == m_pend, "R9 irq status", stat_n_o, !m_pend);
            chk(int'(msel_o) == m_msel && int'(rsel_o) == m_rsel && int'(cyc_o) == m_cyc,
                "R6 config readback", cyc_o, m_cyc);
            chk(en_o == m_en, "R9 enable readback", en_o, m_en);
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic write_cfg(int m, int r, int c);
        cfg_wr = 1; cfg_msel = 3'(m); cfg_rsel = 3'(r); cfg_cyc = CNT_W'(c);
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic do_start();
        start_wr = 1;
        @(negedge clk);
        start_wr = 0;
    endtask

    task automatic wait_idle();
        while (start_o) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_en(bit v);
        en_wr = 1; en_val = v;
        @(negedge clk);
        en_wr = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!start_o && result_o == 0 && stat_n_o && !irq_o && !en_o, "R1 reset outputs", result_o, 0);
        chk(msel_o == 0 && rsel_o == 0 && cyc_o == 0, "R1 reset config", cyc_o, 0);
        cmp_on = 1;

        // Basic window, interrupt disabled: no pending flag (R4, R9)
        write_cfg(0, 0, 5);
        do_start();
        wait_idle();
        chk(stat_n_o && !irq_o, "R9 no set when disabled", stat_n_o, 1);
        chk(result_o != 0, "R4 nonzero count", result_o, m_res);

        // Enabled interrupt; writes and restart during run ignored (R6, R9, R10)
        set_en(1);
        write_cfg(1, 2, 10);
        do_start();
        write_cfg(4, 5, 3);
        do_start();
        chk(cyc_o == 10 && msel_o == 1 && rsel_o == 2, "R6 write ignored while busy", cyc_o, 10);
        wait_idle();
        chk(!stat_n_o && irq_o, "R9 pending after completion", stat_n_o, 0);
        irq_clr = 1; @(negedge clk); irq_clr = 0;
        chk(stat_n_o && !irq_o, "R10 clear works", stat_n_o, 1);

        // Zero window (R7)
        write_cfg(1, 2, 0);
        do_start();
        chk(start_o == 1, "R7 busy one cycle", start_o, 1);
        @(negedge clk);
        chk(start_o == 0 && result_o == 0, "R7 zero result", result_o, 0);

        // Config write with start in the same cycle (R11)
        cfg_wr = 1; cfg_msel = 3'd3; cfg_rsel = 3'd1; cfg_cyc = 16'd4; start_wr = 1;
        @(negedge clk);
        cfg_wr = 0; start_wr = 0;
        @(negedge clk);
        chk(start_o == 1 && cyc_o == 4, "R11 new config used by start", start_o, 1);
        wait_idle();

        // Completion coinciding with clear: set wins (R10)
        write_cfg(4, 3, 3);
        do_start();
        while (m_state != 2) @(negedge clk);
        irq_clr = 1; @(negedge clk); irq_clr = 0;
        chk(irq_o == 1 && stat_n_o == 0, "R10 set beats clear", irq_o, 1);
        irq_clr = 1; @(negedge clk); irq_clr = 0;

        // Saturation (R8)
        write_cfg(2, 2, 120);
        do_start();
        wait_idle();
        chk(int'(result_o) == RES_MAX, "R8 saturated result", result_o, RES_MAX);

        // Every measured and reference select (R2, R3)
        for (int m = 0; m < 5; m++) begin
            for (int r = 0; r < 6; r++) begin
                write_cfg(m, r, 3);
                do_start();
                wait_idle();
                chk(int'(result_o) == m_res, "R2 R3 select sweep", result_o, m_res);
            end
        end

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule